// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host read short byte strings (configuration items) that are held inside the chip. The host writes a 16-bit key to the selector. The key names one item and moves that item's read pointer back to its first byte. Each later read of the data register then returns the next bytes of the item. When the item runs out, the read is padded with zero bytes, and reads past the end return nothing but zeros. Items live in two banks. A key whose index falls outside the configured range leaves the port with no valid item.

All item contents come from a read-only table. Each entry gives a length, a start address in a shared byte ROM and a writable flag. Both table and ROM are computed when the design is elaborated. A parameter picks one of two register layouts:

- **Split layout:** a control register for the key and a separate big-endian data register that can be read up to eight bytes wide.
- **Combined layout:** the 8-bit data register shares the address window of the 16-bit selector.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the port selects bank 0, index 0 (the signature item) at offset 0, with sel_valid high. Four single-byte or one four-byte read from there return 0x51, 0x45, 0x4D, 0x55 in that order.
- R2: A selector load takes bank = key bit 15 and index = key bits 14:0. Every selector load, valid or not, rewinds the read offset to zero.
- R3: An index at or above FILE_BASE + FILE_SLOTS (64 with defaults) marks the selection invalid. sel_valid then reads 0, and data reads return all zeros.
- R4: An N-byte read returns its bytes right-aligned in the low N bytes of rd_data. The first byte of the item stream sits in the most significant of those N bytes, and every bit above byte N-1 is zero.
- R5: If the item ends before N bytes are gathered, the missing low-end bytes are zero. The offset advances only by the bytes actually taken. A read at or past the end returns zero and leaves the offset unchanged.
- R6: An entry of length zero returns zeros, exactly as missing data does.
- R7: A write to the data register changes neither the selection nor the offset, and gives no read response.
- R8: Combined layout (acc_addr 0 = selector, 1 = data):
  - A 1- or 2-byte write at offset 0 loads the selector. A 1-byte write loads {8'h00, acc_wdata[7:0]}.
  - A 1- or 2-byte write at offset 1 is an ignored data write.
  - A 1-byte read at either offset is a data read.
  - Every other access is rejected.
- R9: Split layout (acc_addr 0 = control, 1 = data):
  - Only a 2-byte write to control is accepted, and it loads the key.
  - Data accepts reads and ignored writes of 1 to MAX_RD bytes.
  - Any other access, including an access of 0 bytes or more than MAX_RD bytes, is rejected with no effect.
- R10: rd_valid with rd_data, and acc_reject, are registered. Each pulses for exactly one cycle, in the cycle after the access. A selector load or offset change is seen by the very next access. rd_data is zero whenever rd_valid is low.
- R11: Item contents:
  - Bank 0, index 0 has length 4 and start 0, and is not writable.
  - Any other entry (bank b, index i) has length (5i+3b) mod 13, start (11i+64b+4) mod ROM_BYTES, and writable flag i[0] xor b.
  - ROM bytes 0..3 hold 51 45 4D 55. The ROM byte at address a≥4 is (37a+11) mod 256, and addresses wrap modulo ROM_BYTES.
  - sel_writable shows the current entry's flag while the selection is valid, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | Register offset within the window |
| acc_bytes | input | 4 | Access size in bytes |
| acc_wdata | input | 16 | Write data (key value for selector loads) |
| rd_valid | output | 1 | Read response strobe, one cycle after an accepted data read |
| rd_data | output | 64 | Packed read data, right-aligned |
| acc_reject | output | 1 | Strobe, one cycle after an access the layout does not accept |
| sel_valid | output | 1 | The current selection names an in-range entry |
| sel_writable | output | 1 | Writable flag of the current valid entry |

## Verification
Every result of this block is due exactly one clock after the access that caused it:
- the read data and its strobe;
- the reject strobe;
- the new sel_valid and sel_writable levels after a selector load.

The driver tags each expected item with the cycle count at which it drove the access. The monitor checks that item only once the count has moved past the tag, sampling on the falling edge. As a result, a response arriving a cycle early or late shows up as a mismatch against the queue head. Offset-sensitive cases are chained back to back with no idle cycles: rewind after a load, the partial final read, reads past the end, and reads following ignored or rejected accesses. This shows that each change is already in effect for the very next access.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int KEY_W    = 16;
  localparam int BANK_BIT = 15;
  localparam int IDX_W    = 15;
  localparam int LEN_W    = 16;

  localparam logic [31:0] SIGNATURE = 32'h514D_4D55 ^ 32'h0008_0000;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] start;
    logic             writable;
  } item_desc_t;

  // Signature byte k (k = 0 is the first byte streamed).
  function automatic logic [7:0] sig_byte(input int k);
    logic [31:0] w;
    w = SIGNATURE >> (8 * (3 - k));
    return w[7:0];
  endfunction

  // Content of the shared byte ROM at an already wrapped address.
  function automatic logic [7:0] rom_byte(input int addr);
    int v;
    if (addr < 4) return sig_byte(addr);
    v = (addr * 37 + 11) % 256;
    return 8'(v);
  endfunction

  // Descriptor of entry (bank, idx).
  function automatic item_desc_t item_lookup(input int bank, input int idx,
                                             input int rom_bytes);
    item_desc_t d;
    if (bank == 0 && idx == 0) begin
      d.len      = LEN_W'(4);
      d.start    = '0;
      d.writable = 1'b0;
    end else begin
      d.len      = LEN_W'((idx * 5 + bank * 3) % 13);
      d.start    = LEN_W'((idx * 11 + bank * 64 + 4) % rom_bytes);
      d.writable = ((idx % 2) != 0) ^ (bank != 0);
    end
    return d;
  endfunction

  // Index range check against the exclusive entry limit.
  function automatic logic idx_in_range(input logic [IDX_W-1:0] idx, input int limit);
    return int'(idx) < limit;
  endfunction

  // Bytes available to a read: zero when invalid or at/past the end.
  function automatic int bytes_left(input logic ok, input logic [LEN_W-1:0] len,
                                    input logic [LEN_W-1:0] off);
    if (!ok || off >= len) return 0;
    return int'(len) - int'(off);
  endfunction

endpackage

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode #(
  parameter  int SPLIT_LAYOUT = 1,
  parameter  int MAX_RD       = 8,
  localparam int NB_W         = $clog2(MAX_RD + 1)
) (
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic            acc_addr,
  input  logic [NB_W-1:0] acc_bytes,
  input  logic [15:0]     acc_wdata,
  output logic            sel_load,
  output logic [15:0]     sel_value,
  output logic            data_rd,
  output logic [NB_W-1:0] rd_bytes,
  output logic            reject
);

  logic data_ign;

  generate
    if (SPLIT_LAYOUT != 0) begin : g_split
      logic size_ok;
      assign size_ok   = (acc_bytes != '0) && (acc_bytes <= NB_W'(MAX_RD));
      assign sel_load  = acc_valid && !acc_addr && acc_write && (acc_bytes == NB_W'(2));
      assign data_rd   = acc_valid && acc_addr && !acc_write && size_ok;
      assign data_ign  = acc_valid && acc_addr && acc_write && size_ok;
      assign sel_value = acc_wdata;
      assign rd_bytes  = acc_bytes;
    end else begin : g_comb
      logic narrow;
      assign narrow    = (acc_bytes == NB_W'(1)) || (acc_bytes == NB_W'(2));
      assign sel_load  = acc_valid && acc_write && !acc_addr && narrow;
      assign data_ign  = acc_valid && acc_write && acc_addr && narrow;
      assign data_rd   = acc_valid && !acc_write && (acc_bytes == NB_W'(1));
      assign sel_value = (acc_bytes == NB_W'(1)) ? {8'h00, acc_wdata[7:0]} : acc_wdata;
      assign rd_bytes  = NB_W'(1);
    end
  endgenerate

  assign reject = acc_valid && !(sel_load || data_rd || data_ign);

endmodule

// File: rtl/cfg_item_table.sv
module cfg_item_table
  import cfg_port_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int ROM_BYTES = 256
) (
  input  logic             bank,
  input  logic [IDX_W-1:0] idx,
  output item_desc_t       desc
);

  localparam int NBANK = 2;

  logic [IDX_W-1:0] idx_c;
  item_desc_t       bank_desc [NBANK];

  assign idx_c = idx_in_range(idx, ENTRIES) ? idx : '0;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_comb bank_desc[b] = item_lookup(b, int'(idx_c), ROM_BYTES);
    end
  endgenerate

  assign desc = bank_desc[bank];

endmodule

// File: rtl/cfg_byte_packer.sv
module cfg_byte_packer
  import cfg_port_pkg::*;
#(
  parameter  int MAX_RD    = 8,
  parameter  int ROM_BYTES = 256,
  localparam int NB_W      = $clog2(MAX_RD + 1),
  localparam int RD_W      = 8 * MAX_RD
) (
  input  logic             item_ok,
  input  logic [LEN_W-1:0] item_len,
  input  logic [LEN_W-1:0] item_start,
  input  logic [LEN_W-1:0] offset,
  input  logic [NB_W-1:0]  nbytes,
  output logic [RD_W-1:0]  data,
  output logic [LEN_W-1:0] take
);

  logic [7:0] lane [MAX_RD];

  always_comb begin
    int rem;
    rem  = bytes_left(item_ok, item_len, offset);
    take = LEN_W'((int'(nbytes) < rem) ? int'(nbytes) : rem);
  end

  // Lane p holds stream byte k = N-1-p: first byte most significant.
  generate
    for (genvar p = 0; p < MAX_RD; p++) begin : g_lane
      always_comb begin
        int k;
        k = int'(nbytes) - 1 - p;
        if (p < int'(nbytes) && k < int'(take))
          lane[p] = rom_byte((int'(item_start) + int'(offset) + k) % ROM_BYTES);
        else
          lane[p] = 8'h00;
      end
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < MAX_RD; p++) data[8*p +: 8] = lane[p];
  end

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_port_pkg::*;
#(
  parameter  int SPLIT_LAYOUT = 1,
  parameter  int FILE_BASE    = 32,
  parameter  int FILE_SLOTS   = 32,
  parameter  int MAX_RD       = 8,
  parameter  int ROM_BYTES    = 256,
  localparam int NB_W         = $clog2(MAX_RD + 1),
  localparam int RD_W         = 8 * MAX_RD,
  localparam int ENTRIES      = FILE_BASE + FILE_SLOTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic            acc_addr,
  input  logic [NB_W-1:0] acc_bytes,
  input  logic [15:0]     acc_wdata,
  output logic            rd_valid,
  output logic [RD_W-1:0] rd_data,
  output logic            acc_reject,
  output logic            sel_valid,
  output logic            sel_writable
);

  // Decoded access events.
  logic            sel_load;
  logic [15:0]     sel_value;
  logic            data_rd;
  logic [NB_W-1:0] rd_bytes;
  logic            reject;

  // Selection state.
  logic             cur_bank;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_valid;
  logic [LEN_W-1:0] offset_q;

  item_desc_t       cur_desc;
  logic [RD_W-1:0]  packed_data;
  logic [LEN_W-1:0] take;

  cfg_bus_decode #(.SPLIT_LAYOUT(SPLIT_LAYOUT), .MAX_RD(MAX_RD)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_bytes (acc_bytes),
    .acc_wdata (acc_wdata),
    .sel_load  (sel_load),
    .sel_value (sel_value),
    .data_rd   (data_rd),
    .rd_bytes  (rd_bytes),
    .reject    (reject)
  );

  cfg_item_table #(.ENTRIES(ENTRIES), .ROM_BYTES(ROM_BYTES)) u_table (
    .bank (cur_bank),
    .idx  (cur_idx),
    .desc (cur_desc)
  );

  cfg_byte_packer #(.MAX_RD(MAX_RD), .ROM_BYTES(ROM_BYTES)) u_pack (
    .item_ok    (cur_valid),
    .item_len   (cur_desc.len),
    .item_start (cur_desc.start),
    .offset     (offset_q),
    .nbytes     (rd_bytes),
    .data       (packed_data),
    .take       (take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bank  <= 1'b0;
      cur_idx   <= '0;
      cur_valid <= 1'b1;
      offset_q  <= '0;
    end else if (sel_load) begin
      cur_bank  <= sel_value[BANK_BIT];
      cur_idx   <= sel_value[IDX_W-1:0];
      cur_valid <= idx_in_range(sel_value[IDX_W-1:0], ENTRIES);
      offset_q  <= '0;
    end else if (data_rd) begin
      offset_q  <= offset_q + take;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      acc_reject <= 1'b0;
    end else begin
      rd_valid   <= data_rd;
      rd_data    <= data_rd ? packed_data : '0;
      acc_reject <= reject;
    end
  end

  assign sel_valid    = cur_valid;
  assign sel_writable = cur_valid && cur_desc.writable;

endmodule

// File: rtl/cfg_item_port_checker.sv
module cfg_item_port_checker #(
  parameter int NB_W = 4,
  parameter int RD_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [NB_W-1:0] acc_bytes,
  input logic            rd_valid,
  input logic [RD_W-1:0] rd_data,
  input logic            acc_reject,
  input logic            sel_valid,
  input logic            sel_load,
  input logic [15:0]     offset_q,
  input logic [15:0]     cur_len
);

  assert_read_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> (rd_valid || acc_reject));

  assert_resp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && acc_reject));

  assert_load_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_load |=> (offset_q == 16'd0));

  assert_invalid_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !sel_valid) |=> (rd_data == '0));

  assert_single_byte_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_bytes == NB_W'(1)) |=> (rd_data[RD_W-1:8] == '0));

  assert_offset_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (offset_q <= cur_len));

  assert_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> !rd_valid);

endmodule

bind cfg_item_port cfg_item_port_checker #(.NB_W(NB_W), .RD_W(RD_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_bytes  (acc_bytes),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .acc_reject (acc_reject),
  .sel_valid  (sel_valid),
  .sel_load   (sel_load),
  .offset_q   (offset_q),
  .cur_len    (cur_desc.len)
);

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Index 0: split layout, index 1: combined layout.
  logic        av [2];
  logic        aw [2];
  logic        aa [2];
  logic [3:0]  ab [2];
  logic [15:0] wd [2];
  logic        rv [2];
  logic [63:0] rd [2];
  logic        rj [2];
  logic        sv [2];
  logic        sw [2];

  cfg_item_port #(.SPLIT_LAYOUT(1)) u_cfg_item_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(av[0]), .acc_write(aw[0]), .acc_addr(aa[0]),
    .acc_bytes(ab[0]), .acc_wdata(wd[0]), .rd_valid(rv[0]), .rd_data(rd[0]),
    .acc_reject(rj[0]), .sel_valid(sv[0]), .sel_writable(sw[0]));

  cfg_item_port #(.SPLIT_LAYOUT(0)) u_cfg_item_port_comb (
    .clk(clk), .rst_n(rst_n), .acc_valid(av[1]), .acc_write(aw[1]), .acc_addr(aa[1]),
    .acc_bytes(ab[1]), .acc_wdata(wd[1]), .rd_valid(rv[1]), .rd_data(rd[1]),
    .acc_reject(rj[1]), .sel_valid(sv[1]), .sel_writable(sw[1]));

  int total = 0;
  int failed = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference item contents (R11), written from the requirement text.
  function automatic int ref_len(int b, int i);
    if (b == 0 && i == 0) return 4;
    return (5 * i + 3 * b) % 13;
  endfunction
  function automatic int ref_start(int b, int i);
    if (b == 0 && i == 0) return 0;
    return (11 * i + 64 * b + 4) % 256;
  endfunction
  function automatic bit ref_wr(int b, int i);
    if (b == 0 && i == 0) return 1'b0;
    return (i % 2 == 1) != (b == 1);
  endfunction
  function automatic logic [7:0] ref_byte(int a);
    logic [7:0] sig [4];
    sig[0] = 8'h51; sig[1] = 8'h45; sig[2] = 8'h4D; sig[3] = 8'h55;
    a = a % 256;
    if (a < 4) return sig[a];
    return 8'((37 * a + 11) % 256);
  endfunction

  // Bench model of the selection.
  int m_bank [2];
  int m_idx  [2];
  bit m_ok   [2];
  int m_off  [2];

  typedef struct packed {
    int          stamp;
    bit          rv;
    bit          rj;
    logic [63:0] d;
    bit          sv;
    bit          sw;
  } item_t;

  item_t q0 [$];
  item_t q1 [$];
  string r0 [$];
  string r1 [$];

  task automatic acc(input int u, input bit wr, input bit ad, input int nb,
                     input int wv, input string req);
    item_t it;
    bit sel, rdd, ign;
    int key;
    it = '0;
    it.stamp = cyc;
    sel = 0; rdd = 0; ign = 0; key = wv;
    if (u == 0) begin
      sel = !ad && wr && nb == 2;
      rdd = ad && !wr && nb >= 1 && nb <= 8;
      ign = ad && wr && nb >= 1 && nb <= 8;
    end else begin
      sel = !ad && wr && (nb == 1 || nb == 2);
      ign = ad && wr && (nb == 1 || nb == 2);
      rdd = !wr && nb == 1;
      if (nb == 1) key = wv % 256;
    end
    if (sel) begin
      m_bank[u] = (key / 32768) % 2;
      m_idx[u]  = key % 32768;
      m_ok[u]   = m_idx[u] < 64;
      m_off[u]  = 0;
    end
    if (rdd) begin
      int len, rem, tk;
      logic [63:0] v;
      len = m_ok[u] ? ref_len(m_bank[u], m_idx[u]) : 0;
      rem = (m_off[u] < len) ? len - m_off[u] : 0;
      tk  = (nb < rem) ? nb : rem;
      v = '0;
      for (int k = 0; k < nb; k++)
        v = (v << 8) | ((k < tk) ? 64'(ref_byte(ref_start(m_bank[u], m_idx[u]) + m_off[u] + k)) : 64'd0);
      m_off[u] += tk;
      it.d = v;
    end
    it.rv = rdd;
    it.rj = !(sel || rdd || ign);
    it.sv = m_ok[u];
    it.sw = m_ok[u] && ref_wr(m_bank[u], m_idx[u]);
    av[u] = 1'b1; aw[u] = wr; aa[u] = ad; ab[u] = 4'(nb); wd[u] = 16'(wv);
    if (u == 0) begin q0.push_back(it); r0.push_back(req); end
    else        begin q1.push_back(it); r1.push_back(req); end
    @(negedge clk);
    av[u] = 1'b0;
  endtask

  task automatic mon_check(input int u, input item_t it, input string req);
    check(rv[u] == it.rv && rj[u] == it.rj, "R10", {req, " response strobes"},
          {62'd0, rv[u], rj[u]}, {62'd0, it.rv, it.rj});
    check(rd[u] == it.d, req, "read data", rd[u], it.d);
    check(sv[u] == it.sv && sw[u] == it.sw, req, "selection flags",
          {62'd0, sv[u], sw[u]}, {62'd0, it.sv, it.sw});
  endtask

  // Monitor: each result is due one edge after the access was driven.
  always @(negedge clk) begin
    while (q0.size() > 0 && q0[0].stamp < cyc) mon_check(0, q0.pop_front(), r0.pop_front());
    while (q1.size() > 0 && q1[0].stamp < cyc) mon_check(1, q1.pop_front(), r1.pop_front());
  end

  bit done = 0;

  initial begin
    for (int u = 0; u < 2; u++) begin
      av[u] = 0; aw[u] = 0; aa[u] = 0; ab[u] = 0; wd[u] = 0;
      m_bank[u] = 0; m_idx[u] = 0; m_ok[u] = 1; m_off[u] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      check(sv[u] == 1'b1 && sw[u] == 1'b0, "R1", "reset selection", {63'd0, sv[u]}, 64'd1);
      check(rv[u] == 1'b0 && rj[u] == 1'b0, "R1", "reset strobes", {63'd0, rv[u]}, 64'd0);
    end

    // Split layout.
    acc(0, 0, 1, 4, 0, "R1");          // signature, packed R4
    acc(0, 0, 1, 1, 0, "R5");          // past end
    acc(0, 1, 0, 2, 16'h0001, "R2");
    acc(0, 0, 1, 2, 0, "R4");
    acc(0, 0, 1, 8, 0, "R5");          // 3 bytes then 5 zero pads
    acc(0, 0, 1, 3, 0, "R5");          // at end: zeros
    acc(0, 1, 0, 2, 16'h0001, "R2");   // rewind
    acc(0, 0, 1, 1, 0, "R2");
    acc(0, 1, 0, 2, 16'h8001, "R2");   // bank 1
    acc(0, 0, 1, 8, 0, "R11");
    acc(0, 1, 0, 2, 16'h4001, "R3");   // index 0x4001 out of range
    acc(0, 0, 1, 4, 0, "R3");
    acc(0, 1, 0, 2, 16'h0040, "R3");   // first invalid index
    acc(0, 0, 1, 2, 0, "R3");
    acc(0, 1, 0, 2, 16'h003F, "R3");   // last valid index
    acc(0, 0, 1, 8, 0, "R11");
    acc(0, 1, 0, 2, 16'h000D, "R6");   // zero length
    acc(0, 0, 1, 2, 0, "R6");
    acc(0, 1, 0, 2, 16'h0002, "R7");
    acc(0, 0, 1, 1, 0, "R7");
    acc(0, 1, 1, 1, 16'h00AA, "R7");   // ignored data write
    acc(0, 1, 1, 4, 16'h1234, "R7");
    acc(0, 0, 1, 1, 0, "R7");
    acc(0, 1, 0, 1, 16'h0005, "R9");   // narrow control write
    acc(0, 0, 0, 2, 0, "R9");          // control read
    acc(0, 0, 1, 0, 0, "R9");          // zero bytes
    acc(0, 0, 1, 9, 0, "R9");          // too wide
    acc(0, 0, 1, 3, 0, "R9");          // continues from prior offset
    acc(0, 0, 1, 8, 0, "R5");

    // Combined layout.
    acc(1, 0, 0, 1, 0, "R1");
    acc(1, 0, 1, 1, 0, "R1");
    acc(1, 0, 0, 1, 0, "R1");
    acc(1, 0, 1, 1, 0, "R1");
    acc(1, 0, 0, 1, 0, "R5");
    acc(1, 1, 0, 2, 16'h0002, "R8");
    acc(1, 0, 1, 1, 0, "R8");
    acc(1, 1, 0, 1, 16'hFF01, "R8");   // 1-byte load: key 0x0001
    acc(1, 0, 0, 1, 0, "R8");
    acc(1, 1, 1, 1, 16'h00AA, "R7");
    acc(1, 0, 1, 1, 0, "R7");
    acc(1, 0, 0, 2, 0, "R8");          // 2-byte read rejected
    acc(1, 1, 0, 4, 16'h0003, "R8");   // 4-byte write rejected
    acc(1, 0, 1, 1, 0, "R8");
    acc(1, 1, 0, 2, 16'h8003, "R11");
    acc(1, 0, 0, 1, 0, "R11");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule